// File: doc/BRIEF.md
# Prioritized Interrupt Control Register

This block is the control register for one interrupt source, for example the end-of-conversion signal of an on-chip data converter. It holds a three-bit priority level and a single pending-request flag. Both fields sit in one byte that software reads and writes over a simple register bus made of an address, a write strobe, write data and combinational read data. A one-cycle event pulse from the hardware sets the pending flag. The CPU's acknowledge pulse clears it. Software may also set or clear the flag directly.

A comparator gates the request on its way to the CPU. The interrupt-valid output is high only when three things hold together: the flag is pending, the stored level is strictly above the processor's current priority level, and the global interrupt mask is low. Level 0 therefore turns the source off. The stored level is also driven out so that an outside arbiter can rank this source against others.

Top module: `irq_level_ctl`

## Requirements
- R1: After reset the stored level is 0, the pending flag is 0, irq_valid is 0, and a read at the register address returns 0x00.
- R2: A write at the register address (default 0x70) stores wdata[2:0] as the level and wdata[3] as the pending flag. A read at that address returns {4'b0000, flag, level}, so bits 7..4 always read 0. With no write, event or acknowledge, both fields hold their values.
- R3: A write at any other address changes nothing, and a read at any other address returns 0x00.
- R4: An evt_pulse high at a clock edge makes the flag 1 after that edge.
- R5: An ack_pulse high at a clock edge, without an event at the same edge, makes the flag 0 after that edge.
- R6: An event at the same edge as an acknowledge, or as a software write of flag 0, leaves the flag at 1.
- R7: An acknowledge at the same edge as a software write of flag 1, without an event, leaves the flag at 0. The level field of that write is still stored.
- R8: irq_valid equals flag AND (level > cpu_level, compared as unsigned values, strictly greater) AND NOT glob_mask. It follows cpu_level and glob_mask combinationally and follows register changes from the cycle after the edge.
- R9: With a stored level of 0, irq_valid stays 0 whatever the flag and cpu_level are.
- R10: irq_level always shows the stored level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register bus byte address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational from the address |
| evt_pulse | input | 1 | Hardware interrupt event, one cycle |
| ack_pulse | input | 1 | CPU acceptance of this interrupt, one cycle |
| cpu_level | input | 3 | Processor's current priority level |
| glob_mask | input | 1 | Global interrupt disable (1 blocks everything) |
| irq_valid | output | 1 | Request offered to the CPU |
| irq_level | output | 3 | This source's stored priority level |

## Verification
The assertions check every cycle the conditions that can be stated one edge at a time:
- an event always sets the flag;
- an acknowledge without an event always clears it;
- the flag and level do not move when there is no write, event or acknowledge;
- the mask and a zero level always silence irq_valid;
- a raised irq_valid always has a level above cpu_level;
- reads at other addresses return zero.

Only the bench's scenarios show the exact byte layout on read-back, and that the upper write bits are dropped. They also show the outcome of each simultaneous-event case, including the level still being stored in the acknowledge-plus-write case. Finally, they show the full strict-greater comparison, checked over all 64 pairs of level and cpu_level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQC_ADDR_W  = 8;
  localparam int IRQC_DATA_W  = 8;
  localparam int IRQC_LVL_W   = 3;
  localparam int IRQC_REQ_POS = IRQC_LVL_W;

  // Pending-flag next state. Precedence: hardware event, then acknowledge,
  // then a software write, otherwise hold.
  function automatic logic next_req(input logic cur, input logic evt,
                                    input logic ack, input logic wr_hit,
                                    input logic wr_bit);
    if (evt)         return 1'b1;
    else if (ack)    return 1'b0;
    else if (wr_hit) return wr_bit;
    else             return cur;
  endfunction

  // Strict unsigned compare. Level zero never wins.
  function automatic logic lvl_above(input logic [IRQC_LVL_W-1:0] src,
                                     input logic [IRQC_LVL_W-1:0] cur);
    return (src != '0) && (src > cur);
  endfunction

  // Read-back byte: unused upper bits are zero.
  function automatic logic [IRQC_DATA_W-1:0] pack_view(
      input logic req, input logic [IRQC_LVL_W-1:0] lvl);
    logic [IRQC_DATA_W-1:0] v;
    v = '0;
    v[IRQC_LVL_W-1:0] = lvl;
    v[IRQC_REQ_POS]   = req;
    return v;
  endfunction
endpackage

// File: rtl/irqc_store.sv
module irqc_store import irqc_pkg::*; #(
  parameter logic [IRQC_ADDR_W-1:0] BASE_ADDR = 8'h70
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IRQC_ADDR_W-1:0] bus_addr,
  input  logic                   bus_we,
  input  logic [IRQC_DATA_W-1:0] bus_wdata,
  input  logic                   evt_pulse,
  input  logic                   ack_pulse,
  output logic [IRQC_LVL_W-1:0]  lvl_q,
  output logic                   req_q,
  output logic                   sel_w,
  output logic                   wr_hit_w,
  output logic [IRQC_DATA_W-1:0] bus_rdata
);
  logic                   req_d;
  logic [IRQC_LVL_W-1:0]  lvl_d;
  logic [IRQC_DATA_W-1:0] view_w;

  assign sel_w    = (bus_addr == BASE_ADDR);
  assign wr_hit_w = bus_we && sel_w;

  always_comb begin
    req_d = next_req(req_q, evt_pulse, ack_pulse, wr_hit_w,
                     bus_wdata[IRQC_REQ_POS]);
    lvl_d = wr_hit_w ? bus_wdata[IRQC_LVL_W-1:0] : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      req_q <= req_d;
      lvl_q <= lvl_d;
    end
  end

  assign view_w = pack_view(req_q, lvl_q);

  // Read data: each bit is gated by the address decode.
  for (genvar b = 0; b < IRQC_DATA_W; b++) begin : g_rd
    assign bus_rdata[b] = sel_w & view_w[b];
  end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate import irqc_pkg::*; (
  input  logic                  req_q,
  input  logic [IRQC_LVL_W-1:0] lvl_q,
  input  logic [IRQC_LVL_W-1:0] cpu_level,
  input  logic                  glob_mask,
  output logic                  above_w,
  output logic                  irq_valid
);
  assign above_w   = lvl_above(lvl_q, cpu_level);
  assign irq_valid = req_q && above_w && !glob_mask;
endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl import irqc_pkg::*; #(
  parameter logic [IRQC_ADDR_W-1:0] BASE_ADDR = 8'h70
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IRQC_ADDR_W-1:0] bus_addr,
  input  logic                   bus_we,
  input  logic [IRQC_DATA_W-1:0] bus_wdata,
  output logic [IRQC_DATA_W-1:0] bus_rdata,
  input  logic                   evt_pulse,
  input  logic                   ack_pulse,
  input  logic [IRQC_LVL_W-1:0]  cpu_level,
  input  logic                   glob_mask,
  output logic                   irq_valid,
  output logic [IRQC_LVL_W-1:0]  irq_level
);
  logic [IRQC_LVL_W-1:0] lvl_q;
  logic                  req_q;
  logic                  sel_w;
  logic                  wr_hit_w;
  logic                  above_w;

  irqc_store #(.BASE_ADDR(BASE_ADDR)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .evt_pulse (evt_pulse),
    .ack_pulse (ack_pulse),
    .lvl_q     (lvl_q),
    .req_q     (req_q),
    .sel_w     (sel_w),
    .wr_hit_w  (wr_hit_w),
    .bus_rdata (bus_rdata)
  );

  irqc_gate gate_i (
    .req_q     (req_q),
    .lvl_q     (lvl_q),
    .cpu_level (cpu_level),
    .glob_mask (glob_mask),
    .above_w   (above_w),
    .irq_valid (irq_valid)
  );

  assign irq_level = lvl_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk import irqc_pkg::*; #(
  parameter logic [IRQC_ADDR_W-1:0] BASE_ADDR = 8'h70
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [IRQC_ADDR_W-1:0] bus_addr,
  input logic [IRQC_DATA_W-1:0] bus_wdata,
  input logic [IRQC_DATA_W-1:0] bus_rdata,
  input logic                   evt_pulse,
  input logic                   ack_pulse,
  input logic [IRQC_LVL_W-1:0]  cpu_level,
  input logic                   glob_mask,
  input logic                   irq_valid,
  input logic [IRQC_LVL_W-1:0]  irq_level,
  input logic                   wr_hit_w,
  input logic                   req_q,
  input logic [IRQC_LVL_W-1:0]  lvl_q
);
  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> req_q);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && !evt_pulse) |=> !req_q);

  p_evt_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && (ack_pulse || (wr_hit_w && !bus_wdata[IRQC_REQ_POS]))) |=> req_q);

  p_ack_beats_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && !evt_pulse && wr_hit_w && bus_wdata[IRQC_REQ_POS]) |=> !req_q);

  p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_pulse && !ack_pulse && !wr_hit_w) |=> ($stable(req_q) && $stable(lvl_q)));

  p_foreign_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != BASE_ADDR) |-> (bus_rdata == '0));

  p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    glob_mask |-> !irq_valid);

  p_valid_above_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (req_q && (irq_level > cpu_level)));

  p_level_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == '0) |-> !irq_valid);
endmodule

bind irq_level_ctl irqc_chk #(.BASE_ADDR(BASE_ADDR)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .evt_pulse (evt_pulse),
  .ack_pulse (ack_pulse),
  .cpu_level (cpu_level),
  .glob_mask (glob_mask),
  .irq_valid (irq_valid),
  .irq_level (irq_level),
  .wr_hit_w  (wr_hit_w),
  .req_q     (req_q),
  .lvl_q     (lvl_q)
);

// File: tb/irq_level_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_level_ctl_tb_top;
  localparam logic [7:0] REG_A = 8'h70;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = REG_A;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       evt_pulse = 1'b0;
  logic       ack_pulse = 1'b0;
  logic [2:0] cpu_level = 3'd0;
  logic       glob_mask = 1'b0;
  logic       irq_valid;
  logic [2:0] irq_level;

  int n_cmp = 0;
  int n_bad = 0;

  // Scoreboard: tag queue plus packed {rdata, valid, level} queue.
  string      q_tag[$];
  logic [11:0] q_exp[$];

  // Bench-side model state.
  logic [2:0] m_lvl = 3'd0;
  logic       m_req = 1'b0;

  always #2 clk = ~clk;

  irq_level_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .ack_pulse(ack_pulse), .cpu_level(cpu_level), .glob_mask(glob_mask),
    .irq_valid(irq_valid), .irq_level(irq_level)
  );

  task automatic compare(input string tag, input logic [11:0] exp_v);
    logic [11:0] act;
    act = {bus_rdata, irq_valid, irq_level};
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual rdata=%02h valid=%0b level=%0d expected rdata=%02h valid=%0b level=%0d",
               tag, act[11:4], act[3], act[2:0], exp_v[11:4], exp_v[3], exp_v[2:0]);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic [7:0] a, input logic we, input logic [7:0] wd,
                      input logic ev, input logic ak, input logic [2:0] cl,
                      input logic mk, input string tag);
    logic       hit, nreq, v;
    logic [2:0] nlvl;
    logic [7:0] rd;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd;
    evt_pulse = ev; ack_pulse = ak; cpu_level = cl; glob_mask = mk;
    hit  = we && (a == REG_A);
    nreq = ev ? 1'b1 : (ak ? 1'b0 : (hit ? wd[3] : m_req));
    nlvl = hit ? wd[2:0] : m_lvl;
    m_req = nreq; m_lvl = nlvl;
    rd = (a == REG_A) ? {4'b0000, nreq, nlvl} : 8'h00;
    v  = nreq && (nlvl > cl) && !mk;
    q_tag.push_back(tag);
    q_exp.push_back({rd, v, nlvl});
  endtask

  // Monitor: compares one queued item per clock, just after the edge.
  initial begin
    forever begin
      wait (q_tag.size() > 0);
      @(posedge clk);
      #1;
      compare(q_tag.pop_front(), q_exp.pop_front());
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual run still busy expected done");
    finish_run();
  end

  initial begin
    // R1: state while reset is held
    #5;
    compare("R1 reset", {8'h00, 1'b0, 3'd0});
    @(negedge clk);
    rst_n = 1'b1;
    step(REG_A, 0, 8'h00, 0, 0, 3'd0, 0, "R1 after reset");

    step(REG_A, 1, 8'h05, 0, 0, 3'd0, 0, "R2 write level 5");
    step(REG_A, 1, 8'hF3, 0, 0, 3'd0, 0, "R2 upper bits dropped");
    step(8'h71, 1, 8'h0F, 0, 0, 3'd0, 0, "R3 foreign write/read");
    step(REG_A, 0, 8'h00, 0, 0, 3'd0, 0, "R3 register unchanged");

    step(REG_A, 0, 8'h00, 1, 0, 3'd1, 0, "R4 event sets flag");
    step(REG_A, 0, 8'h00, 0, 0, 3'd3, 0, "R8 equal level blocked");
    step(REG_A, 0, 8'h00, 0, 0, 3'd2, 0, "R8 level above passes");
    step(REG_A, 0, 8'h00, 0, 0, 3'd2, 1, "R8 mask blocks");
    step(REG_A, 0, 8'h00, 0, 1, 3'd0, 0, "R5 ack clears");

    step(REG_A, 1, 8'h0F, 0, 0, 3'd6, 0, "R10 software set level 7");
    step(REG_A, 1, 8'h07, 1, 0, 3'd6, 0, "R6 event beats write 0");
    step(REG_A, 0, 8'h00, 1, 1, 3'd6, 0, "R6 event beats ack");
    step(REG_A, 1, 8'h0C, 0, 1, 3'd0, 0, "R7 ack beats write 1");
    step(REG_A, 1, 8'h08, 0, 0, 3'd0, 0, "R9 level 0 flag set");
    step(REG_A, 0, 8'h00, 1, 0, 3'd0, 0, "R9 level 0 with event");
    step(REG_A, 1, 8'h09, 0, 0, 3'd0, 0, "R8 level 1 over 0");

    for (int l = 0; l < 8; l++) begin
      for (int c = 0; c < 8; c++) begin
        step(REG_A, 1, {4'b0000, 1'b1, l[2:0]}, 0, 0, c[2:0], 0, "R8 sweep");
      end
    end

    @(negedge clk);
    bus_we = 1'b0; evt_pulse = 1'b0; ack_pulse = 1'b0;
    wait (q_tag.size() == 0);
    @(posedge clk);
    #2;
    finish_run();
  end
endmodule